// File: doc/BRIEF.md
# Quad-Channel Register Access Hub

This block is the host-facing register front end of a four-channel serial controller. One chip select, one address bus, one write-data bus and one read-data bus serve all four channels, and a single interrupt line summarises them. Each host access is decoded into a region bit, a channel number and a register offset. Channel accesses go to that channel's register bank. Accesses to the global region go to a small block of shared registers.

Each channel bank uses the classic 16550 arrangement at offsets 0 to 7. Setting bit 7 of the line-control register swaps offsets 0 and 1 over to the two baud divisor latches. Offsets 8 to 15 hold enhanced registers that can be reached directly, whatever value the line-control register holds.

The global region holds three registers:
- a control register whose broadcast bit copies every channel write into all four banks;
- a per-channel interrupt enable register;
- a status register that shows the raw interrupt request of every channel at once.

A strap input picks the bus protocol. In Intel style there are separate read and write strobes. In Motorola style a data strobe qualifies the transfer and a read/write line gives its direction. Serial shifting, FIFOs and baud generation are not part of this block. The banks are plain storage.

Top module: `quad_reg_hub`

## Requirements
- R1: After reset every channel register, both divisor latches of each channel, the interrupt enable register and the broadcast bit read 0. `rdata` and `irq_out` are 0.
- R2: With `motorola_sel`=0 (Intel style), a transfer needs `cs_n`=0. `dir_line`=0 is a write. `strb_n`=0 with `dir_line`=1 is a read. `rdata` carries the addressed register on the rising edge after the read is first seen, and carries 0 whenever no read was present at the previous edge.
- R3: With `motorola_sel`=1 (Motorola style), a transfer needs `cs_n`=0 and `strb_n`=0. `dir_line`=1 reads and `dir_line`=0 writes. With `strb_n`=1 nothing is written, even when `dir_line`=0.
- R4: A write is applied once, at the first rising edge where the write qualifier is active. Data changes while the strobe stays held are ignored.
- R5: `addr[6]`=0 selects the channel region, with `addr[5:4]` as the channel and `addr[3:0]` as the offset. Channels store their registers independently of each other.
- R6: When bit 7 of a channel's line-control register (offset 3) is 1, offsets 0 and 1 reach divisor latches low and high. When it is 0, they reach separate data and interrupt-enable storage.
- R7: Offsets 8 to 15 of every channel can be written and read back whatever the line-control register holds.
- R8: When bit 0 of global offset 2 (broadcast) is 1, a channel write stores its data at the same offset in all four channels. Each channel applies its own divisor-latch selection.
- R9: Reads are never broadcast. In broadcast mode a read returns only the addressed channel's value and changes no register.
- R10: `addr[6]`=1 selects the global region at offset `addr[3:0]`. Global writes are never replicated into channel banks. Clearing broadcast makes later channel writes affect only the addressed channel.
- R11: `irq_out` equals the OR over channels of `chan_irq[i]` AND enable bit i. The enable bits are bits [3:0] of global offset 1. `irq_out` is registered, one edge after its inputs.
- R12: A read of global offset 0 returns `chan_irq` in bits [3:0] and 0 in bits [7:4].
- R13: With `cs_n`=1 no write takes place, and a read strobe yields `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| motorola_sel | input | 1 | Bus protocol strap: 0 Intel style, 1 Motorola style |
| cs_n | input | 1 | Shared active-low chip select |
| strb_n | input | 1 | Intel: read strobe (active low); Motorola: data strobe (active low) |
| dir_line | input | 1 | Intel: write strobe (active low); Motorola: 1 read, 0 write |
| addr | input | 7 | {global, channel[1:0], offset[3:0]} |
| wdata | input | 8 | Write data |
| chan_irq | input | 4 | Per-channel interrupt requests |
| rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
A write lands in its register at the first rising edge that sees the write qualifier. Read data appears on `rdata` at the rising edge after the read strobe is applied, and `irq_out` follows `chan_irq` and the enables one edge later. The bench changes every input on a falling edge and samples `rdata` and `irq_out` on the next falling edge. It therefore always reads the value due one rising edge after the stimulus. A read-back always comes in a separate transfer after the write transfer has been released, so it sees the stored value and never a value still in transit.

// File: rtl/qhub_pkg.sv
package qhub_pkg;

    localparam int CH_W   = 2;
    localparam int OFS_W  = 4;
    localparam int DW     = 8;
    localparam int NCH    = 1 << CH_W;
    localparam int NREG   = 1 << OFS_W;
    localparam int AW     = 1 + CH_W + OFS_W;

    localparam logic [OFS_W-1:0] OFS_DATA = OFS_W'(0);
    localparam logic [OFS_W-1:0] OFS_IENB = OFS_W'(1);
    localparam logic [OFS_W-1:0] OFS_LCTL = OFS_W'(3);
    localparam int               DLAB_BIT = 7;

    localparam logic [OFS_W-1:0] G_STATUS = OFS_W'(0);
    localparam logic [OFS_W-1:0] G_IRQEN  = OFS_W'(1);
    localparam logic [OFS_W-1:0] G_CTRL   = OFS_W'(2);

    typedef struct packed {
        logic             glob;
        logic [CH_W-1:0]  ch;
        logic [OFS_W-1:0] ofs;
    } haddr_t;

    typedef struct packed {
        logic          wr;
        logic          rd;
        haddr_t        a;
        logic [DW-1:0] d;
    } hacc_t;

    function automatic haddr_t split_addr(input logic [AW-1:0] raw);
        return haddr_t'(raw);
    endfunction

endpackage

// File: rtl/qhub_bus_if.sv
module qhub_bus_if
    import qhub_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          moto,
    input  logic          cs_n,
    input  logic          strb_n,
    input  logic          dir_line,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output hacc_t         acc
);
    logic wr_lvl, rd_lvl, wr_seen;

    always_comb begin
        if (moto) begin
            wr_lvl = !cs_n && !strb_n && !dir_line;
            rd_lvl = !cs_n && !strb_n && dir_line;
        end else begin
            wr_lvl = !cs_n && !dir_line;
            rd_lvl = !cs_n && !strb_n && dir_line;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wr_seen <= 1'b0;
        else     wr_seen <= wr_lvl;
    end

    always_comb begin
        acc.wr = wr_lvl && !wr_seen;
        acc.rd = rd_lvl;
        acc.a  = split_addr(addr);
        acc.d  = wdata;
    end

    // R4: a held strobe never yields two write pulses in a row
    a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
        acc.wr |=> !acc.wr);

endmodule

// File: rtl/qhub_chan_bank.sv
module qhub_chan_bank
    import qhub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] div_lo, div_hi;
    logic          dlab, hit_lo, hit_hi;

    assign dlab   = regs[OFS_LCTL][DLAB_BIT];
    assign hit_lo = dlab && (ofs == OFS_DATA);
    assign hit_hi = dlab && (ofs == OFS_IENB);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
            div_lo <= '0;
            div_hi <= '0;
        end else if (we) begin
            if (hit_lo)      div_lo    <= wdata;
            else if (hit_hi) div_hi    <= wdata;
            else             regs[ofs] <= wdata;
        end
    end

    always_comb begin
        if (hit_lo)      rdata = div_lo;
        else if (hit_hi) rdata = div_hi;
        else             rdata = regs[ofs];
    end

    // R6: divisor latches only move on a write
    a_r6_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(div_lo) && $stable(div_hi)));

    // R6: writing the line-control offset updates the latch-select bit
    a_r6_dlab_update: assert property (@(posedge clk) disable iff (rst)
        (we && ofs == OFS_LCTL) |=> (dlab == $past(wdata[DLAB_BIT])));

endmodule

// File: rtl/qhub_global.sv
module qhub_global
    import qhub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    wdata,
    input  logic [NCH-1:0]   chan_irq,
    output logic             bcast,
    output logic             irq_out,
    output logic [DW-1:0]    rdata
);
    logic [NCH-1:0] irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en  <= '0;
            bcast   <= 1'b0;
            irq_out <= 1'b0;
        end else begin
            if (we && ofs == G_IRQEN) irq_en <= wdata[NCH-1:0];
            if (we && ofs == G_CTRL)  bcast  <= wdata[0];
            irq_out <= |(chan_irq & irq_en);
        end
    end

    always_comb begin
        rdata = '0;
        case (ofs)
            G_STATUS: rdata[NCH-1:0] = chan_irq;
            G_IRQEN:  rdata[NCH-1:0] = irq_en;
            G_CTRL:   rdata[0]       = bcast;
            default:  rdata          = '0;
        endcase
    end

    // R10: broadcast mode only changes through a global write
    a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(bcast));

    // R11: no enabled request -> interrupt low next cycle
    a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
        ((chan_irq & irq_en) == '0) |=> !irq_out);

    // R11: any enabled request -> interrupt high next cycle
    a_r11_raise: assert property (@(posedge clk) disable iff (rst)
        ((chan_irq & irq_en) != '0) |=> irq_out);

endmodule

// File: rtl/quad_reg_hub.sv
module quad_reg_hub
    import qhub_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           motorola_sel,
    input  logic           cs_n,
    input  logic           strb_n,
    input  logic           dir_line,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] chan_irq,
    output logic [DW-1:0]  rdata,
    output logic           irq_out
);
    hacc_t         acc;
    logic          bcast;
    logic [DW-1:0] bank_rd [NCH];
    logic [DW-1:0] glob_rd, sel_rd;

    qhub_bus_if u_bus (
        .clk      (clk),
        .rst      (rst),
        .moto     (motorola_sel),
        .cs_n     (cs_n),
        .strb_n   (strb_n),
        .dir_line (dir_line),
        .addr     (addr),
        .wdata    (wdata),
        .acc      (acc)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic bank_we;
        assign bank_we = acc.wr && !acc.a.glob &&
                         (bcast || acc.a.ch == CH_W'(c));
        qhub_chan_bank u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (bank_we),
            .ofs   (acc.a.ofs),
            .wdata (acc.d),
            .rdata (bank_rd[c])
        );
    end

    qhub_global u_glob (
        .clk      (clk),
        .rst      (rst),
        .we       (acc.wr && acc.a.glob),
        .ofs      (acc.a.ofs),
        .wdata    (acc.d),
        .chan_irq (chan_irq),
        .bcast    (bcast),
        .irq_out  (irq_out),
        .rdata    (glob_rd)
    );

    assign sel_rd = acc.a.glob ? glob_rd : bank_rd[acc.a.ch];

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (acc.rd) rdata <= sel_rd;
        else             rdata <= '0;
    end

    // R13: a deselected bus returns zero read data one edge later
    a_r13_idle_zero: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (rdata == '0));

endmodule

// File: tb/tb_quad_reg_hub.sv
module tb_quad_reg_hub;
    logic       clk = 0;
    logic       rst;
    logic       motorola_sel;
    logic       cs_n, strb_n, dir_line;
    logic [6:0] addr;
    logic [7:0] wdata;
    logic [3:0] chan_irq;
    logic [7:0] rdata;
    logic       irq_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] m_reg [4][16];
    logic [7:0] m_dl  [4][2];
    logic [3:0] m_en;
    logic       m_bc;

    quad_reg_hub dut (
        .clk(clk), .rst(rst), .motorola_sel(motorola_sel), .cs_n(cs_n),
        .strb_n(strb_n), .dir_line(dir_line), .addr(addr), .wdata(wdata),
        .chan_irq(chan_irq), .rdata(rdata), .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000) begin
            checks++; fails++;
            $display("FAIL watchdog: got cycle %0d exp completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [6:0] ca(input int c, input int o);
        return {1'b0, 2'(c), 4'(o)};
    endfunction

    function automatic logic [6:0] ga(input int o);
        return {1'b1, 2'b00, 4'(o)};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    task automatic ref_write(input logic [6:0] a, input logic [7:0] d);
        int c = a[5:4];
        int o = a[3:0];
        if (a[6]) begin
            if (o == 1) m_en = d[3:0];
            if (o == 2) m_bc = d[0];
        end else begin
            for (int k = 0; k < 4; k++)
                if (m_bc || k == c) begin
                    if (m_reg[k][3][7] && o < 2) m_dl[k][o] = d;
                    else                         m_reg[k][o] = d;
                end
        end
    endtask

    function automatic logic [7:0] ref_read(input logic [6:0] a);
        int c = a[5:4];
        int o = a[3:0];
        if (a[6]) begin
            if (o == 0) return {4'h0, chan_irq};
            if (o == 1) return {4'h0, m_en};
            if (o == 2) return {7'h0, m_bc};
            return 8'h00;
        end
        if (m_reg[c][3][7] && o < 2) return m_dl[c][o];
        return m_reg[c][o];
    endfunction

    task automatic idle();
        cs_n = 1; strb_n = 1; dir_line = 1;
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 0; dir_line = 0;
        strb_n = motorola_sel ? 1'b0 : 1'b1;
        @(posedge clk);
        @(negedge clk);
        idle();
        ref_write(a, d);
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; cs_n = 0; strb_n = 0; dir_line = 1;
        @(posedge clk);
        @(negedge clk);
        d = rdata;
        idle();
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a);
        logic [7:0] v;
        bus_rd(a, v);
        check(req, v, ref_read(a));
    endtask

    initial begin
        logic [7:0] v;
        motorola_sel = 0; idle(); addr = '0; wdata = '0; chan_irq = '0;
        for (int c = 0; c < 4; c++) begin
            for (int o = 0; o < 16; o++) m_reg[c][o] = '0;
            m_dl[c][0] = '0; m_dl[c][1] = '0;
        end
        m_en = '0; m_bc = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        check("R1 rdata", rdata, 8'h00);
        check("R1 irq_out", {7'h0, irq_out}, 8'h00);
        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 16; o++) rd_chk("R1 reg", ca(c, o));
        rd_chk("R1 irqen", ga(1));
        rd_chk("R1 ctrl", ga(2));

        // R2 R3 R5 R7: sweep every channel/offset in both bus styles
        for (int m = 0; m < 2; m++) begin
            motorola_sel = m[0];
            for (int c = 0; c < 4; c++)
                for (int o = 0; o < 16; o++)
                    bus_wr(ca(c, o), 8'((c * 16 + o) ^ (m * 8'h5A)));
            for (int c = 0; c < 4; c++)
                for (int o = 0; o < 16; o++)
                    rd_chk(m ? "R3 R5 sweep" : "R2 R5 sweep", ca(c, o));
        end
        @(negedge clk);
        check("R2 idle rdata", rdata, 8'h00);

        // R3: Intel-style write pins in Motorola mode do nothing
        motorola_sel = 1;
        @(negedge clk);
        addr = ca(2, 14); wdata = 8'hEE; cs_n = 0; strb_n = 1; dir_line = 0;
        @(posedge clk); @(negedge clk); idle();
        rd_chk("R3 no strobe", ca(2, 14));
        motorola_sel = 0;

        // R6: divisor latches behind line-control bit 7
        bus_wr(ca(1, 3), 8'h83);
        bus_wr(ca(1, 0), 8'h11);
        bus_wr(ca(1, 1), 8'h22);
        rd_chk("R6 dll", ca(1, 0));
        rd_chk("R6 dlm", ca(1, 1));
        bus_wr(ca(1, 3), 8'h03);
        rd_chk("R6 data", ca(1, 0));
        rd_chk("R6 ienb", ca(1, 1));
        check("R6 dll distinct", ref_read(ca(1, 0)) == 8'h11 ? 8'h1 : 8'h0, 8'h0);

        // R7: enhanced offsets reachable under any line-control value
        bus_wr(ca(0, 3), 8'hBF);
        bus_wr(ca(0, 9), 8'h96);
        rd_chk("R7 enh", ca(0, 9));
        bus_wr(ca(0, 3), 8'h00);
        bus_wr(ca(0, 15), 8'h69);
        rd_chk("R7 enh", ca(0, 15));

        // R4: held write strobe, data changes mid-strobe
        @(negedge clk);
        addr = ca(0, 13); wdata = 8'hA5; cs_n = 0; strb_n = 1; dir_line = 0;
        @(posedge clk); @(negedge clk);
        wdata = 8'h5A;
        @(posedge clk); @(negedge clk); idle();
        ref_write(ca(0, 13), 8'hA5);
        rd_chk("R4 held", ca(0, 13));

        // R8: broadcast write, channel 1 has divisor select set
        bus_wr(ca(1, 3), 8'h80);
        bus_wr(ga(2), 8'h01);
        rd_chk("R10 ctrl", ga(2));
        bus_wr(ca(2, 10), 8'hC3);
        bus_wr(ca(3, 0), 8'h7E);
        for (int c = 0; c < 4; c++) begin
            rd_chk("R8 bcast", ca(c, 10));
            rd_chk("R8 bcast dl", ca(c, 0));
        end

        // R9: reads in broadcast mode return the addressed channel only
        for (int c = 0; c < 4; c++) rd_chk("R9 read", ca(c, 12));
        for (int c = 0; c < 4; c++) rd_chk("R9 after", ca(c, 12));

        // R10: global write not replicated; broadcast off again
        bus_wr(ga(1), 8'h05);
        rd_chk("R10 irqen", ga(1));
        for (int c = 0; c < 4; c++) rd_chk("R10 chan", ca(c, 1));
        bus_wr(ga(2), 8'h00);
        bus_wr(ca(0, 10), 8'h3C);
        for (int c = 0; c < 4; c++) rd_chk("R10 single", ca(c, 10));

        // R11 R12: all enable x request combinations
        for (int e = 0; e < 16; e++) begin
            bus_wr(ga(1), 8'(e));
            for (int p = 0; p < 16; p++) begin
                @(negedge clk);
                chan_irq = 4'(p);
                @(posedge clk); @(negedge clk);
                check("R11 irq", {7'h0, irq_out}, {7'h0, |(4'(p) & 4'(e))});
                rd_chk("R12 status", ga(0));
            end
        end
        chan_irq = 0;

        // R13: deselected read and write
        @(negedge clk);
        addr = ca(3, 11); cs_n = 1; strb_n = 0; dir_line = 1;
        @(posedge clk); @(negedge clk);
        check("R13 rdata", rdata, 8'h00);
        addr = ca(3, 11); wdata = 8'hF0; cs_n = 1; strb_n = 1; dir_line = 0;
        @(posedge clk); @(negedge clk); idle();
        rd_chk("R13 no write", ca(3, 11));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule